// File: doc/BRIEF.md
# Load-Multiple Register Transfer Sequencer

This block runs one load-multiple instruction inside an overlapped, strictly in-order pipeline model. A caller hands it a base memory address, the index of the first destination register and a word count through a valid/ready handshake. The sequencer then issues one data-fetch read per cycle at consecutive word addresses. Memory returns each word one cycle after its request, and the block writes that word into the next register, with the register index wrapping around the register file.

The block owns the single write path into the register set. The following instruction asks for that path through a request input. The block holds it back with a stall signal from the first cycle of the transfer until the cycle after the final register write. When the transfer completes, the block records how far the instruction ran past a fixed template of two data-fetch and two execute cycles. The overrun is the number of cycles beyond four, or zero when the instruction fits. A zero count is a no-op that occupies the four template cycles and never stalls the next instruction.

Top module: `ldmseq_top`

## Requirements
- R1: `startReady` is high exactly when the sequencer is idle. A request presented while it is busy is not accepted then, stays pending, and is accepted in the first cycle `startReady` returns high.
- R2: For a count N ≥ 1, `memReqValid` is high in cycles 1..N after acceptance (cycle 0 is the accepting edge). Cycle k carries address base + k − 1, modulo 2^ADDR_W.
- R3: Each word requested in cycle k is written in cycle k + 1, from `memRspData`, to register (first + k − 1) modulo NUM_REGS, with `rfWe` high.
- R4: A transfer of N ≥ 1 words lasts N + 1 cycles. `done` is a one-cycle pulse in cycle N + 1, which carries the final register write. A single-word load ends in cycle 2.
- R5: `holdNext` is high in cycles 1..N+1 of a transfer with N ≥ 1 and low from the cycle after `done`. `nextWrGrant` equals `nextWrValid` whenever `holdNext` is low and is 0 whenever it is high.
- R6: The sequencer's own write and a granted next-instruction write never occur in the same cycle. With no sequencer write, `rfWe` and the write index and data come from the next-instruction request when it is granted.
- R7: `overrun` is cleared when a start is accepted. On `done` it takes max(0, cycles used − 4), which is max(0, N − 3). It holds that value until the next accepted start.
- R8: A count of zero issues no read and no register write, raises no `holdNext`, pulses `done` in cycle 4, and leaves `overrun` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Load-multiple request present |
| startReady | output | 1 | Sequencer idle, request taken this cycle |
| startBase | input | ADDR_W | First word address |
| startReg | input | IDX_W | First destination register |
| startCount | input | CNT_W | Number of registers to load |
| memReqValid | output | 1 | Data-fetch read issued this cycle |
| memReqAddr | output | ADDR_W | Word address of the read |
| memRspData | input | DATA_W | Word returned for the previous cycle's read |
| nextWrValid | input | 1 | Following instruction wants to write a register |
| nextWrIdx | input | IDX_W | Following instruction's destination register |
| nextWrData | input | DATA_W | Following instruction's write data |
| nextWrGrant | output | 1 | Following instruction's write performed this cycle |
| rfWe | output | 1 | Register file write enable |
| rfWrIdx | output | IDX_W | Register file write index |
| rfWrData | output | DATA_W | Register file write data |
| holdNext | output | 1 | Order-preserving stall to the following instruction |
| done | output | 1 | Final cycle of the instruction |
| overrun | output | CNT_W+2 | Cycles beyond the four-cycle template |

## Verification
A wrong remaining-word counter shows up as a read count that differs from the request. It also moves `done` to the wrong cycle, and the overrun differs by the same amount. All of this is visible within one cycle of the faulty count. An address or index register that steps wrongly puts a bad address or a bad `rfWrIdx` on the ports at the very next transfer cycle. A stall released one cycle early shows as a granted next-instruction write in the final write cycle, and the single-writer rule flags this at once. Random counts from zero to twenty, mixed with wrap, single-word, no-op and held-off start cases, reach each of these paths.

// File: rtl/ldmseq_pkg.sv
package ldmseq_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // start accepted: capture base and first register
    logic advance;  // a fetch is issued: step the address
    logic wrStep;   // a fetched word is written: step the register index
    logic finish;   // last cycle of the instruction: record overrun
  } seqStrobe_t;

endpackage

// File: rtl/ldmseq_ctrl.sv
module ldmseq_ctrl
  import ldmseq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int ELAP_W  = 7,
  parameter int TPL_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startValid,
  input  logic [CNT_W-1:0]  startCount,
  output logic              startReady,
  output logic              memReqValid,
  output logic              seqWr,
  output logic              holdNext,
  output logic              done,
  output seqStrobe_t        strobe,
  output logic [ELAP_W-1:0] elapsed
);

  logic              busy;
  logic              noop;
  logic              pendWr;
  logic [CNT_W-1:0]  reqLeft;
  logic [ELAP_W-1:0] elapsedQ;
  logic              accept;
  logic              lastWr;
  logic              noopEnd;

  assign accept      = startValid && !busy;
  assign startReady  = !busy;
  assign memReqValid = busy && !noop && (reqLeft != '0);
  assign seqWr       = pendWr;
  assign lastWr      = pendWr && (reqLeft == '0);
  assign noopEnd     = busy && noop && (elapsedQ == ELAP_W'(TPL_LEN));
  assign done        = lastWr || noopEnd;
  assign holdNext    = busy && !noop;
  assign elapsed     = elapsedQ;

  always_comb begin
    strobe.load    = accept;
    strobe.advance = memReqValid;
    strobe.wrStep  = seqWr;
    strobe.finish  = done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      noop     <= 1'b0;
      pendWr   <= 1'b0;
      reqLeft  <= '0;
      elapsedQ <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      noop     <= (startCount == '0);
      pendWr   <= 1'b0;
      reqLeft  <= startCount;
      elapsedQ <= ELAP_W'(1);
    end else if (busy) begin
      elapsedQ <= elapsedQ + 1'b1;
      pendWr   <= memReqValid;
      if (memReqValid) reqLeft <= reqLeft - 1'b1;
      if (done) begin
        busy <= 1'b0;
        noop <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ldmseq_dpath.sv
module ldmseq_dpath
  import ldmseq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4,
  parameter int ELAP_W   = 7,
  parameter int TPL_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startBase,
  input  logic [IDX_W-1:0]  startReg,
  input  logic [ELAP_W-1:0] elapsed,
  input  logic              holdNext,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              nextWrValid,
  input  logic [IDX_W-1:0]  nextWrIdx,
  input  logic [DATA_W-1:0] nextWrData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              nextWrGrant,
  output logic              rfWe,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic [ELAP_W-1:0] overrun
);

  localparam bit IDX_POW2 = (NUM_REGS == (1 << IDX_W));

  logic [ADDR_W-1:0] addrQ;
  logic [IDX_W-1:0]  idxQ;
  logic [IDX_W-1:0]  idxNext;
  logic [ELAP_W-1:0] overrunQ;

  generate
    if (IDX_POW2) begin : g_wrapPow2
      assign idxNext = idxQ + 1'b1;
    end else begin : g_wrapCmp
      assign idxNext = (idxQ == IDX_W'(NUM_REGS - 1)) ? '0 : idxQ + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ    <= '0;
      idxQ     <= '0;
      overrunQ <= '0;
    end else begin
      if (strobe.load) begin
        addrQ    <= startBase;
        idxQ     <= startReg;
        overrunQ <= '0;
      end else begin
        if (strobe.advance) addrQ <= addrQ + 1'b1;
        if (strobe.wrStep)  idxQ  <= idxNext;
        if (strobe.finish)
          overrunQ <= (elapsed > ELAP_W'(TPL_LEN)) ? elapsed - ELAP_W'(TPL_LEN) : '0;
      end
    end
  end

  // single write path into the register set; the sequencer wins
  assign nextWrGrant = nextWrValid && !holdNext;
  assign rfWe        = strobe.wrStep || nextWrGrant;
  assign rfWrIdx     = strobe.wrStep ? idxQ : nextWrIdx;
  assign rfWrData    = strobe.wrStep ? memRspData : nextWrData;
  assign memReqAddr  = addrQ;
  assign overrun     = overrunQ;

endmodule

// File: rtl/ldmseq_top.sv
module ldmseq_top
  import ldmseq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int CNT_W    = 5,
  parameter int TPL_DF   = 2,
  parameter int TPL_EX   = 2,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ELAP_W  = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startValid,
  output logic              startReady,
  input  logic [ADDR_W-1:0] startBase,
  input  logic [IDX_W-1:0]  startReg,
  input  logic [CNT_W-1:0]  startCount,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              nextWrValid,
  input  logic [IDX_W-1:0]  nextWrIdx,
  input  logic [DATA_W-1:0] nextWrData,
  output logic              nextWrGrant,
  output logic              rfWe,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              holdNext,
  output logic              done,
  output logic [ELAP_W-1:0] overrun
);

  localparam int TPL_LEN = TPL_DF + TPL_EX;

  seqStrobe_t        strobe;
  logic              seqWr;
  logic [ELAP_W-1:0] elapsed;

  ldmseq_ctrl #(
    .CNT_W(CNT_W), .ELAP_W(ELAP_W), .TPL_LEN(TPL_LEN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .startValid(startValid), .startCount(startCount), .startReady(startReady),
    .memReqValid(memReqValid), .seqWr(seqWr), .holdNext(holdNext),
    .done(done), .strobe(strobe), .elapsed(elapsed)
  );

  ldmseq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .IDX_W(IDX_W), .ELAP_W(ELAP_W), .TPL_LEN(TPL_LEN)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .startBase(startBase), .startReg(startReg), .elapsed(elapsed),
    .holdNext(holdNext), .memRspData(memRspData),
    .nextWrValid(nextWrValid), .nextWrIdx(nextWrIdx), .nextWrData(nextWrData),
    .memReqAddr(memReqAddr), .nextWrGrant(nextWrGrant),
    .rfWe(rfWe), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .overrun(overrun)
  );

endmodule

// File: rtl/ldmseq_chk.sv
module ldmseq_chk #(
  parameter int ADDR_W = 16,
  parameter int ELAP_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startValid,
  input logic              startReady,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              seqWr,
  input logic              nextWrGrant,
  input logic              rfWe,
  input logic              holdNext,
  input logic              done,
  input logic [ELAP_W-1:0] overrun
);

  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startValid && startReady) |=> !startReady);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && $past(memReqValid)) |-> (memReqAddr == ADDR_W'($past(memReqAddr) + 1'b1)));

  // R3
  write_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(memReqValid) |-> (seqWr && rfWe));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdNext |-> !nextWrGrant);

  // R5
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !holdNext);

  // R6
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seqWr |-> !nextWrGrant);

  // R7
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !(startValid && startReady)) |=> $stable(overrun));

endmodule

bind ldmseq_top ldmseq_chk #(.ADDR_W(ADDR_W), .ELAP_W(ELAP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .startValid(startValid), .startReady(startReady),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr), .seqWr(seqWr),
  .nextWrGrant(nextWrGrant), .rfWe(rfWe), .holdNext(holdNext),
  .done(done), .overrun(overrun)
);

// File: tb/ldmseq_tb.sv
module ldmseq_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [15:0] startBase = '0;
  logic [3:0]  startReg = '0;
  logic [4:0]  startCount = '0;
  logic        memReqValid;
  logic [15:0] memReqAddr;
  logic [31:0] memRspData = '0;
  logic        nextWrValid = 1'b0;
  logic [3:0]  nextWrIdx = '0;
  logic [31:0] nextWrData = '0;
  logic        nextWrGrant;
  logic        rfWe;
  logic [3:0]  rfWrIdx;
  logic [31:0] rfWrData;
  logic        holdNext;
  logic        done;
  logic [6:0]  overrun;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldmseq_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .startValid(startValid), .startReady(startReady),
    .startBase(startBase), .startReg(startReg), .startCount(startCount),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memRspData(memRspData),
    .nextWrValid(nextWrValid), .nextWrIdx(nextWrIdx), .nextWrData(nextWrData),
    .nextWrGrant(nextWrGrant), .rfWe(rfWe), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .holdNext(holdNext), .done(done), .overrun(overrun)
  );

  function automatic logic [31:0] memPat(logic [15:0] a);
    return {a ^ 16'h5a3c, ~a};
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) memRspData <= memPat(memReqAddr);

  function automatic int expOverrun(int cnt);
    return (cnt > 3) ? cnt - 3 : 0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(logic [15:0] base, logic [3:0] rIdx, int cnt, bit nv);
    int total = (cnt == 0) ? 4 : cnt + 1;
    logic [3:0]  nIdx  = 4'($urandom);
    logic [31:0] nData = $urandom;
    @(negedge clk);
    nextWrValid = nv; nextWrIdx = nIdx; nextWrData = nData;
    startValid = 1'b1; startBase = base; startReg = rIdx; startCount = 5'(cnt);
    chk(startReady == 1'b1, "R1", "ready when idle", 32'(startReady), 1);
    @(negedge clk);
    startValid = 1'b0;
    for (int k = 1; k <= total; k++) begin
      bit expReq = (cnt > 0) && (k <= cnt);
      bit expSeq = (cnt > 0) && (k >= 2);
      bit expGnt = nv && (cnt == 0);
      chk(memReqValid == expReq, (cnt == 0) ? "R8" : "R2", "memReqValid", 32'(memReqValid), 32'(expReq));
      if (expReq)
        chk(memReqAddr == 16'(base + k - 1), "R2", "memReqAddr", 32'(memReqAddr), 32'(16'(base + k - 1)));
      chk(rfWe == (expSeq || expGnt), (cnt == 0) ? "R8" : "R3", "rfWe", 32'(rfWe), 32'(expSeq || expGnt));
      if (expSeq) begin
        chk(rfWrIdx == 4'(rIdx + k - 2), "R3", "rfWrIdx", 32'(rfWrIdx), 32'(4'(rIdx + k - 2)));
        chk(rfWrData == memPat(16'(base + k - 2)), "R3", "rfWrData", rfWrData, memPat(16'(base + k - 2)));
      end else if (expGnt) begin
        chk(rfWrIdx == nIdx && rfWrData == nData, "R6", "next write path", rfWrData, nData);
      end
      chk(holdNext == (cnt > 0), (cnt == 0) ? "R8" : "R5", "holdNext", 32'(holdNext), 32'(cnt > 0));
      chk(nextWrGrant == expGnt, "R6", "nextWrGrant", 32'(nextWrGrant), 32'(expGnt));
      chk(done == (k == total), (cnt == 0) ? "R8" : "R4", "done", 32'(done), 32'(k == total));
      chk(startReady == 1'b0, "R1", "ready while busy", 32'(startReady), 0);
      @(negedge clk);
    end
    chk(holdNext == 1'b0 && done == 1'b0, "R5", "released after done", 32'({holdNext, done}), 0);
    chk(nextWrGrant == nv, "R5", "grant after release", 32'(nextWrGrant), 32'(nv));
    chk(startReady == 1'b1, "R1", "ready after done", 32'(startReady), 1);
    chk(overrun == 7'(expOverrun(cnt)), "R7", "overrun", 32'(overrun), 32'(expOverrun(cnt)));
    nextWrValid = 1'b0;
  endtask

  task automatic holdOffTest();
    @(negedge clk);
    startValid = 1'b1; startBase = 16'h0200; startReg = 4'd0; startCount = 5'd3;
    @(negedge clk);
    // second request presented while busy
    startBase = 16'h0300; startReg = 4'd5; startCount = 5'd2;
    for (int k = 1; k <= 4; k++) begin
      chk(startReady == 1'b0, "R1", "held off while busy", 32'(startReady), 0);
      if (k <= 3)
        chk(memReqAddr == 16'(16'h0200 + k - 1), "R1", "busy op addr", 32'(memReqAddr), 32'(16'h0200 + k - 1));
      @(negedge clk);
    end
    chk(startReady == 1'b1 && memReqValid == 1'b0, "R1", "idle cycle", 32'({startReady, memReqValid}), 32'b10);
    @(negedge clk);
    startValid = 1'b0;
    chk(memReqValid == 1'b1 && memReqAddr == 16'h0300, "R1", "pending start taken", 32'(memReqAddr), 32'h300);
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1 && rfWrIdx == 4'd6, "R4", "held-off op end", 32'(rfWrIdx), 6);
    @(negedge clk);
    chk(overrun == 7'd0 && done == 1'b0, "R7", "held-off op overrun", 32'(overrun), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(startReady == 1'b1, "R1", "reset ready", 32'(startReady), 1);
    chk(holdNext == 1'b0 && done == 1'b0, "R5", "reset hold/done", 32'({holdNext, done}), 0);
    chk(memReqValid == 1'b0 && rfWe == 1'b0, "R2", "reset idle ports", 32'({memReqValid, rfWe}), 0);
    chk(overrun == 7'd0, "R7", "reset overrun", 32'(overrun), 0);

    runOp(16'h0100, 4'd3, 7, 1'b1);   // seven words: eight cycles, overrun 4
    runOp(16'h0400, 4'd9, 1, 1'b0);   // single word: ends in cycle 2
    runOp(16'h0500, 4'd2, 0, 1'b1);   // no-op with next writes flowing
    runOp(16'hfffe, 4'd14, 5, 1'b1);  // address and index wrap
    runOp(16'h0600, 4'd0, 3, 1'b0);   // fits template exactly
    runOp(16'h0700, 4'd1, 4, 1'b1);   // one cycle over
    runOp(16'h0800, 4'd15, 31, 1'b1); // largest count
    holdOffTest();

    for (int i = 0; i < 40; i++)
      runOp(16'($urandom), 4'($urandom), int'($urandom_range(0, 20)), 1'($urandom));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule